// File: doc/BRIEF.md
# RTC Control, Status and Update Sequencing Registers

This block holds the four control and status bytes of a real-time clock, mapped at byte addresses 0x0A to 0x0D, and sequences the once-per-second update of a separate time counter. A host reaches it through a byte-wide read/write port with an 8-bit address. The block counts pulses from an external time base (a fixed number of ticks per second, derived from a 32.768 kHz crystal). Once per second it emits a one-cycle update strobe to the counter. A configurable number of ticks before each strobe it raises an update-in-progress flag, so that software knows when the counter is about to change.

The sequencer has four states. HALT means the divider is stopped and ticks are ignored. WAIT counts ticks with the flag low. LEAD counts the last ticks with the flag high. UPD is the single strobe cycle. Its transitions are as follows:
- HALT to WAIT when the divider is enabled. A 010 restart code loads half a second; any other enabling code loads a full second.
- WAIT to LEAD on the tick that leaves exactly the lead count.
- LEAD to UPD on the final tick.
- UPD back to WAIT, reloaded with a full second, or to HALT if the divider has since been disabled.
- Any counting state back to WAIT with a half-second load when 010 is rewritten.
- Any counting state to HALT when the divider is disabled.

Three events set interrupt flags: a periodic-rate event, an alarm event and the update strobe. Each flag is combined with its enable bit to drive an interrupt output. A read of the flag register clears the flags.

Top module: `rtc_timebase_ctl`

## Requirements
- R1: Register 0x0A reads {UIP, OS[2:0], RS[3:0]} from bit 7 down. OS and RS are written from data bits 6:4 and 3:0. RS drives `rate_sel_o`. Bit 7 is UIP, which is read-only, so writes to it have no effect.
- R2: OS codes 010 and 011 set both `osc_on_o` and `div_run_o`. Codes 110 and 111 set `osc_on_o` and clear `div_run_o`. Codes 000, 001, 100 and 101 clear both.
- R3: After OS code 010 is written, the first `upd_stb_o` follows exactly TICKS_PER_SEC/2 ticks. Later strobes follow every TICKS_PER_SEC ticks. Rewriting 010 restarts the half-second count. Enabling with code 011 from HALT gives the first strobe after TICKS_PER_SEC ticks.
- R4: `uip_o` and bit 7 of register 0x0A rise in the cycle after the tick that leaves UIP_LEAD ticks before the update. They stay high through the strobe cycle and are low in the cycle after the strobe.
- R5: While bit 7 of register 0x0B (transfer inhibit) is 1, UIP reads 0 and `uip_o` is 0. The update strobes still occur on schedule.
- R6: Register 0x0B holds, from bit 7 down: inhibit, periodic enable, alarm enable, update enable, a reserved bit, and three format bits. The reserved bit always reads 0. Reset clears bits 6:3 and leaves bits 7 and 2:0 unchanged.
- R7: Register 0x0C reads {INTF, PF, AF, UF, 0000}. PF is set by `periodic_evt_i`, AF by `alarm_evt_i`, and UF in the cycle after an update strobe. Reset clears all flags.
- R8: A read of 0x0C returns the flags held before that cycle and then clears them. A set event in the same cycle as the read wins, so that flag is 1 afterwards.
- R9: INTF and `irq_o` equal (PF and periodic enable) or (AF and alarm enable) or (UF and update enable).
- R10: Register 0x0D reads `batt_ok_i` (sampled one clock earlier) in bit 7 and 0 in bits 6:0. Writes to 0x0C and 0x0D have no effect. Unmapped addresses read 0.
- R11: `upd_stb_o` is a single-cycle pulse and always follows a tick. Ticks are ignored while the divider is disabled, so no strobe occurs. All four registers can be read and written in every sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tick_i | input | 1 | Time-base tick, one-cycle pulse |
| periodic_evt_i | input | 1 | Periodic-rate event from the external divider |
| alarm_evt_i | input | 1 | Alarm match event |
| batt_ok_i | input | 1 | Backup source valid |
| upd_stb_o | output | 1 | One-cycle update strobe to the time counter |
| uip_o | output | 1 | Update in progress |
| irq_o | output | 1 | Interrupt request (INTF) |
| rate_sel_o | output | 4 | Periodic rate select |
| osc_on_o | output | 1 | Oscillator enable |
| div_run_o | output | 1 | Divider chain enable |

## Verification
The collision that matters is a read of register 0x0C landing in the same cycle that a flag's set event arrives. The read must return the old byte, and the new flag must survive the read-clear. The bench drives a read of 0x0C together with a periodic event at one clock edge. It expects 0x00 on the bus in that cycle and 0xC0 on the following read. The random phase also lets reads and events coincide freely, and judges each read against a reference flag model in which the set takes priority over the clear.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

    typedef enum logic [1:0] {
        SQ_HALT = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_LEAD = 2'd2,
        SQ_UPD  = 2'd3
    } seq_state_t;

    localparam logic [7:0] REG_A_ADDR = 8'h0A;
    localparam logic [7:0] REG_B_ADDR = 8'h0B;
    localparam logic [7:0] REG_C_ADDR = 8'h0C;
    localparam logic [7:0] REG_D_ADDR = 8'h0D;

    localparam logic [2:0] OS_HALF_START = 3'b010;

    // divider runs for 01x
    function automatic logic os_div_on(input logic [2:0] os);
        return os[2:1] == 2'b01;
    endfunction

    // oscillator runs for 01x and 11x
    function automatic logic os_osc_on(input logic [2:0] os);
        return os[1];
    endfunction

endpackage

// File: rtl/rtc_ctl_regfile.sv
module rtc_ctl_regfile
    import rtc_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       batt_ok_i,
    output logic [2:0] os_o,
    output logic [3:0] rs_o,
    output logic       uti_o,
    output logic       pie_o,
    output logic       aie_o,
    output logic       uie_o,
    output logic [2:0] fmt_o,
    output logic       vrt_o,
    output logic       restart_o
);

    logic       wr_a;
    logic       wr_b;
    logic [2:0] os_q;
    logic [3:0] rs_q;
    logic       uti_q;
    logic [2:0] fmt_q;
    logic [2:0] en_q;
    logic       vrt_q;
    logic       unused_wbits;

    assign wr_a = wr_en && (addr == REG_A_ADDR);
    assign wr_b = wr_en && (addr == REG_B_ADDR);
    assign unused_wbits = wdata[3];

    // Mode and rate bits: untouched by reset
    always_ff @(posedge clk) begin
        if (wr_a) begin
            os_q <= wdata[6:4];
            rs_q <= wdata[3:0];
        end
        if (wr_b) begin
            uti_q <= wdata[7];
            fmt_q <= wdata[2:0];
        end
    end

    // Interrupt enables: cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 3'b000;
            vrt_q <= 1'b0;
        end else begin
            if (wr_b) begin
                en_q <= wdata[6:4];
            end
            vrt_q <= batt_ok_i;
        end
    end

    always_comb begin
        os_o      = os_q;
        rs_o      = rs_q;
        uti_o     = uti_q;
        pie_o     = en_q[2];
        aie_o     = en_q[1];
        uie_o     = en_q[0];
        fmt_o     = fmt_q;
        vrt_o     = vrt_q;
        restart_o = wr_a && (wdata[6:4] == OS_HALF_START);
    end

    // R6
    regb_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> (pie_o == $past(wdata[6])) && (aie_o == $past(wdata[5]))
                 && (uie_o == $past(wdata[4])));

    // R1
    rega_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_a |=> $stable(os_o) && $stable(rs_o));

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
    import rtc_ctl_pkg::*;
#(
    parameter int TICKS_PER_SEC = 64,
    parameter int UIP_LEAD      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic div_run_i,
    input  logic restart_i,
    input  logic uti_i,
    output logic upd_stb_o,
    output logic uip_o
);

    localparam int CW = $clog2(TICKS_PER_SEC + 1);
    localparam logic [CW-1:0] LOAD_FULL  = CW'(TICKS_PER_SEC);
    localparam logic [CW-1:0] LOAD_HALF  = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] LEAD_ENTRY = CW'(UIP_LEAD + 1);
    localparam logic [CW-1:0] ONE        = CW'(1);

    seq_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SQ_HALT: begin
                if (restart_i) begin
                    st_d  = SQ_WAIT;
                    cnt_d = LOAD_HALF;
                end else if (div_run_i) begin
                    st_d  = SQ_WAIT;
                    cnt_d = LOAD_FULL;
                end
            end
            SQ_WAIT: begin
                if (restart_i) begin
                    cnt_d = LOAD_HALF;
                end else if (!div_run_i) begin
                    st_d = SQ_HALT;
                end else if (tick_i) begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == LEAD_ENTRY) begin
                        st_d = SQ_LEAD;
                    end
                end
            end
            SQ_LEAD: begin
                if (restart_i) begin
                    st_d  = SQ_WAIT;
                    cnt_d = LOAD_HALF;
                end else if (!div_run_i) begin
                    st_d = SQ_HALT;
                end else if (tick_i) begin
                    if (cnt_q == ONE) begin
                        st_d = SQ_UPD;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            SQ_UPD: begin
                cnt_d = tick_i ? (LOAD_FULL - ONE) : LOAD_FULL;
                if (restart_i) begin
                    st_d  = SQ_WAIT;
                    cnt_d = LOAD_HALF;
                end else if (div_run_i) begin
                    st_d = SQ_WAIT;
                end else begin
                    st_d = SQ_HALT;
                end
            end
            default: begin
                st_d  = SQ_HALT;
                cnt_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        upd_stb_o = (st_q == SQ_UPD);
        uip_o     = ((st_q == SQ_LEAD) || (st_q == SQ_UPD)) && !uti_i;
    end

    // R11
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |=> !upd_stb_o);

    // R11
    stb_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_stb_o) |-> $past(tick_i));

    // R4
    lead_before_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_stb_o) |-> $past(st_q == SQ_LEAD));

    // R4
    uip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |=> !uip_o);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_run_i && !restart_i) |=> !upd_stb_o);

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
    parameter int N_FLAGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_clr_i,
    input  logic [N_FLAGS-1:0] set_i,
    input  logic [N_FLAGS-1:0] en_i,
    output logic [N_FLAGS-1:0] flag_o,
    output logic               intf_o
);

    logic [N_FLAGS-1:0] flag_q;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        // Set takes priority over read-clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (rd_clr_i) begin
                flag_q[i] <= 1'b0;
            end
        end

        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);

        // R8
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr_i && !set_i[i]) |=> !flag_o[i]);
    end

    always_comb begin
        flag_o = flag_q;
        intf_o = |(flag_q & en_i);
    end

endmodule

// File: rtl/rtc_timebase_ctl.sv
module rtc_timebase_ctl
    import rtc_ctl_pkg::*;
#(
    parameter int TICKS_PER_SEC = 64,
    parameter int UIP_LEAD      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_i,
    input  logic       periodic_evt_i,
    input  logic       alarm_evt_i,
    input  logic       batt_ok_i,
    output logic       upd_stb_o,
    output logic       uip_o,
    output logic       irq_o,
    output logic [3:0] rate_sel_o,
    output logic       osc_on_o,
    output logic       div_run_o
);

    logic [2:0] os;
    logic [3:0] rs;
    logic       uti, pie, aie, uie, vrt, restart;
    logic [2:0] fmt;
    logic [2:0] flags;
    logic       intf;
    logic       stb;
    logic       uip;
    logic       rd_c;

    rtc_ctl_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .batt_ok_i (batt_ok_i),
        .os_o      (os),
        .rs_o      (rs),
        .uti_o     (uti),
        .pie_o     (pie),
        .aie_o     (aie),
        .uie_o     (uie),
        .fmt_o     (fmt),
        .vrt_o     (vrt),
        .restart_o (restart)
    );

    rtc_upd_seq #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_LEAD      (UIP_LEAD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .div_run_i (os_div_on(os)),
        .restart_i (restart),
        .uti_i     (uti),
        .upd_stb_o (stb),
        .uip_o     (uip)
    );

    assign rd_c = bus_rd && (bus_addr == REG_C_ADDR);

    // flags ordered {PF, AF, UF}
    rtc_irq_flags #(.N_FLAGS(3)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_clr_i (rd_c),
        .set_i    ({periodic_evt_i, alarm_evt_i, stb}),
        .en_i     ({pie, aie, uie}),
        .flag_o   (flags),
        .intf_o   (intf)
    );

    always_comb begin
        unique case (bus_addr)
            REG_A_ADDR: bus_rdata = {uip, os, rs};
            REG_B_ADDR: bus_rdata = {uti, pie, aie, uie, 1'b0, fmt};
            REG_C_ADDR: bus_rdata = {intf, flags, 4'b0000};
            REG_D_ADDR: bus_rdata = {vrt, 7'b0};
            default:    bus_rdata = 8'h00;
        endcase
    end

    always_comb begin
        upd_stb_o  = stb;
        uip_o      = uip;
        irq_o      = intf;
        rate_sel_o = rs;
        osc_on_o   = os_osc_on(os);
        div_run_o  = os_div_on(os);
    end

    // R5
    uti_blocks_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uti |-> !uip_o);

    // R7
    uf_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |=> flags[0]);

endmodule

// File: tb/rtc_timebase_ctl_bench.sv
module rtc_timebase_ctl_bench;

    localparam int TPS  = 16;
    localparam int LEAD = 3;
    localparam int HALF = TPS / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_i = 1'b0;
    logic       periodic_evt_i = 1'b0;
    logic       alarm_evt_i = 1'b0;
    logic       batt_ok_i = 1'b1;
    logic       upd_stb_o, uip_o, irq_o, osc_on_o, div_run_o;
    logic [3:0] rate_sel_o;

    int checks = 0;
    int fails = 0;
    int ticks_sent = 0;
    int stb_cnt = 0;
    int last_stb_tick = -1;
    int uip_rises = 0;
    int last_uip_tick = -1;
    int uip_late = 0;
    logic uip_prev = 1'b0;
    logic stb_prev = 1'b0;

    // reference model for the random phase
    logic [2:0] m_os;
    logic [3:0] m_rs;
    logic [7:0] m_b;
    logic       m_pf, m_af, m_uf;

    always #4 clk = ~clk;

    rtc_timebase_ctl #(
        .TICKS_PER_SEC (TPS),
        .UIP_LEAD      (LEAD)
    ) u_rtc_timebase_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .tick_i         (tick_i),
        .periodic_evt_i (periodic_evt_i),
        .alarm_evt_i    (alarm_evt_i),
        .batt_ok_i      (batt_ok_i),
        .upd_stb_o      (upd_stb_o),
        .uip_o          (uip_o),
        .irq_o          (irq_o),
        .rate_sel_o     (rate_sel_o),
        .osc_on_o       (osc_on_o),
        .div_run_o      (div_run_o)
    );

    always @(posedge clk) begin
        if (upd_stb_o) begin
            stb_cnt++;
            last_stb_tick = ticks_sent;
        end
        if (uip_o && !uip_prev) begin
            uip_rises++;
            last_uip_tick = ticks_sent;
        end
        if (stb_prev && uip_o) uip_late++;
        uip_prev = uip_o;
        stb_prev = upd_stb_o;
    end

    function automatic logic m_irq();
        return (m_pf & m_b[6]) | (m_af & m_b[5]) | (m_uf & m_b[4]);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h0A:   return {1'b0, m_os, m_rs};
            8'h0B:   return m_b;
            8'h0C:   return {m_irq(), m_pf, m_af, m_uf, 4'b0000};
            8'h0D:   return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_drop(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_i = 1'b1;
            ticks_sent++;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int s0, s1, u0;
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        @(negedge clk);
        bus_addr = 8'h0B; #1;
        chk((bus_rdata & 8'h78) == 8'h00, "R6 reset enables", bus_rdata & 8'h78, 0);
        rd_chk(8'h0C, 8'h00, "R7 reset flags");
        rd_chk(8'h0D, 8'h80, "R10 battery bit");
        chk(irq_o == 1'b0, "R9 reset irq", irq_o, 0);
        chk(upd_stb_o == 1'b0, "R11 reset strobe", upd_stb_o, 0);
        chk(uip_o == 1'b0, "R4 reset uip", uip_o, 0);

        // start with 010, update interrupt enabled
        wr(8'h0B, 8'h10);
        wr(8'h0A, 8'h25);
        ticks_sent = 0;
        rd_chk(8'h0A, 8'h25, "R1 reg A readback");
        chk(rate_sel_o == 4'd5, "R1 rate select", rate_sel_o, 5);
        chk(osc_on_o && div_run_o, "R2 code 010", {osc_on_o, div_run_o}, 3);
        tick_n(HALF);
        chk(stb_cnt == 1, "R3 first strobe count", stb_cnt, 1);
        chk(last_stb_tick == HALF, "R3 half second", last_stb_tick, HALF);
        chk(last_uip_tick == HALF - LEAD, "R4 uip lead", last_uip_tick, HALF - LEAD);
        chk(irq_o == 1'b1, "R9 update irq", irq_o, 1);
        rd_chk(8'h0C, 8'h90, "R7 UF and INTF");
        rd_chk(8'h0C, 8'h00, "R8 read clears");
        chk(irq_o == 1'b0, "R9 irq cleared", irq_o, 0);

        tick_n(TPS);
        chk(stb_cnt == 2, "R3 second strobe", stb_cnt, 2);
        chk(last_stb_tick == HALF + TPS, "R3 full period", last_stb_tick, HALF + TPS);
        chk(last_uip_tick == HALF + TPS - LEAD, "R4 uip lead 2", last_uip_tick, HALF + TPS - LEAD);
        chk(uip_late == 0, "R4 uip low after strobe", uip_late, 0);

        // restart mid-second
        tick_n(5);
        wr(8'h0A, 8'h25);
        ticks_sent = 0;
        tick_n(HALF);
        chk(stb_cnt == 3, "R3 restart strobe", stb_cnt, 3);
        chk(last_stb_tick == HALF, "R3 restart timing", last_stb_tick, HALF);

        // transfer inhibit
        wr(8'h0B, 8'h90);
        u0 = uip_rises;
        tick_n(TPS);
        chk(stb_cnt == 4, "R5 strobe under inhibit", stb_cnt, 4);
        chk(uip_rises == u0, "R5 uip held low", uip_rises, u0);
        wr(8'h0B, 8'h10);

        // 11x keeps divider off
        wr(8'h0A, 8'h63);
        chk(osc_on_o && !div_run_o, "R2 code 110", {osc_on_o, div_run_o}, 2);
        rd_chk(8'h0A, 8'h63, "R1 reg A 110");
        s0 = stb_cnt;
        tick_n(TPS + 4);
        chk(stb_cnt == s0, "R11 no strobe while stopped", stb_cnt, s0);
        wr(8'h0A, 8'h00);
        chk(!osc_on_o && !div_run_o, "R2 code 000", {osc_on_o, div_run_o}, 0);

        // 011 from halt: full second
        wr(8'h0A, 8'h30);
        ticks_sent = 0;
        s1 = stb_cnt;
        tick_n(TPS);
        chk(stb_cnt == s1 + 1, "R3 code 011 strobe", stb_cnt, s1 + 1);
        chk(last_stb_tick == TPS, "R3 code 011 timing", last_stb_tick, TPS);
        wr(8'h0A, 8'h60);
        repeat (3) @(negedge clk);
        rd_drop(8'h0C);

        // read-only bits and registers
        wr(8'h0A, 8'hE5);
        rd_chk(8'h0A, 8'h65, "R1 UIP bit read-only");
        wr(8'h0C, 8'hFF);
        wr(8'h0D, 8'h7F);
        rd_chk(8'h0C, 8'h00, "R10 write to C ignored");
        rd_chk(8'h0D, 8'h80, "R10 write to D ignored");
        wr(8'h0B, 8'h7F);
        rd_chk(8'h0B, 8'h77, "R6 reserved reads zero");

        // collision: read-clear with a set in the same cycle
        wr(8'h0B, 8'h70);
        @(negedge clk);
        bus_addr = 8'h0C; bus_rd = 1'b1; periodic_evt_i = 1'b1;
        #1;
        chk(bus_rdata == 8'h00, "R8 collision read value", bus_rdata, 0);
        @(negedge clk);
        bus_rd = 1'b0; periodic_evt_i = 1'b0;
        rd_chk(8'h0C, 8'hC0, "R8 set wins over clear");
        @(negedge clk);
        alarm_evt_i = 1'b1;
        @(negedge clk);
        alarm_evt_i = 1'b0;
        chk(irq_o == 1'b1, "R9 alarm irq", irq_o, 1);
        rd_chk(8'h0C, 8'hA0, "R7 AF flag");
        rd_chk(8'h0C, 8'h00, "R8 AF cleared");

        // random phase, divider held stopped
        wr(8'h0B, 8'h00);
        wr(8'h0A, 8'h60);
        m_os = 3'b110; m_rs = 4'h0; m_b = 8'h00;
        m_pf = 1'b0; m_af = 1'b0; m_uf = 1'b0;
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] a, d;
            logic pe, ae;
            @(negedge clk);
            op = int'($urandom % 4);
            a  = 8'h0A + 8'($urandom % 5);
            d  = 8'($urandom);
            pe = ($urandom % 4) == 0;
            ae = ($urandom % 5) == 0;
            if (a == 8'h0A && d[6:5] == 2'b01) d[6] = 1'b1;
            bus_addr = a; bus_wdata = d;
            bus_wr = (op == 0);
            bus_rd = (op == 1);
            periodic_evt_i = pe;
            alarm_evt_i = ae;
            #1;
            if (op == 1) chk(bus_rdata == exp_rd(a), "R8 random read", bus_rdata, exp_rd(a));
            chk(irq_o == m_irq(), "R9 random irq", irq_o, m_irq());
            if (op == 0 && a == 8'h0A) begin m_os = d[6:4]; m_rs = d[3:0]; end
            if (op == 0 && a == 8'h0B) m_b = d & 8'hF7;
            if (op == 1 && a == 8'h0C) begin m_pf = 1'b0; m_af = 1'b0; m_uf = 1'b0; end
            if (pe) m_pf = 1'b1;
            if (ae) m_af = 1'b1;
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; periodic_evt_i = 1'b0; alarm_evt_i = 1'b0;
        chk(upd_stb_o == 1'b0, "R11 quiet after random", upd_stb_o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule